// File: doc/BRIEF.md
# Monitor Result Register Bank

This block holds the latest 8-bit measurement for each of three monitored channels: a sense voltage, a source voltage and an auxiliary input. A free-running converter delivers a byte with a capture strobe and a 2-bit channel select. The byte waits in a per-channel staging register. A clock divider marks a fixed update period, ten per second by default. At each period mark a short sequencer copies the staged bytes into the host-visible result registers, one channel per cycle, always in the same order.

A host reads and writes the bank through a simple port with a 2-bit address. One control register carries a test-mode bit. While the bit is set, the converter can neither stage nor publish new values, and the host may write the three result registers and read them back. This lets software be exercised against known readings. When test mode is cleared, the written values stay until the next period mark replaces them with staged converter data.

Top module: `mon_result_bank`

## Requirements
- R1: After reset all four addresses (0 sense result, 1 source result, 2 auxiliary result, 3 control) read 0x00.
- R2: A capture strobe with select 0, 1 or 2 stages its byte for the sense, source or auxiliary channel respectively, and touches only that channel. Select 3 is ignored. A staged byte does not appear at the read port before the next publication.
- R3: Publications start every CLK_HZ/UPDATE_HZ clock cycles.
- R4: Within a publication the sense result is written first, the source result on the next cycle and the auxiliary result on the cycle after that.
- R5: Control register bit 0 is the test-mode bit. It reads back as written, and the other control bits always read 0.
- R6: While test mode is set, converter captures are ignored and no publication changes any result register.
- R7: While test mode is set, host writes to addresses 0 to 2 update the addressed result register and read back on the following cycle.
- R8: While test mode is clear, host writes to addresses 0 to 2 leave the result registers unchanged.
- R9: After test mode is cleared, the result registers keep the host-written values until the next publication, which loads the bytes staged before test mode was entered.
- R10: Reads are combinational: host_rdata shows the register selected by host_addr in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cap_valid | input | 1 | Converter capture strobe |
| cap_sel | input | 2 | Channel of the captured byte |
| cap_data | input | 8 | Captured conversion byte |
| host_wr | input | 1 | Host write enable |
| host_addr | input | 2 | Host register address |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data |

## Verification
The bench watches the exact cycle in which each result lands. A sequencer that wrote all channels at once, or in the wrong order, would show the auxiliary value one cycle early. It measures the spacing between two publications, which an off-by-one divider would stretch or shrink by a cycle. It drives converter strobes during test mode and then clears the mode. A bank that kept staging during the freeze would then publish the frozen-time bytes instead of the older ones. It also issues host writes in normal mode, which a missing mode gate would let through, and it uses select 3, which a loose decoder would route into a real channel.

// File: rtl/mon_pkg.sv
package mon_pkg;
  localparam int unsigned RES_W  = 8;
  localparam int unsigned NUM_CH = 3;
  localparam int unsigned ADDR_W = 2;

  typedef logic [RES_W-1:0] res_t;

  typedef enum logic [ADDR_W-1:0] {
    ADR_SENSE  = 2'd0,
    ADR_SOURCE = 2'd1,
    ADR_AUX    = 2'd2,
    ADR_CTRL   = 2'd3
  } reg_addr_e;

  localparam int unsigned CTRL_TEST_BIT = 0;
endpackage

// File: rtl/mon_rate_div.sv
module mon_rate_div #(
  parameter int unsigned DIV = 100
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int unsigned CNT_W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    tick  = (cnt_q == LAST);
    cnt_d = tick ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/mon_stage.sv
module mon_stage
  import mon_pkg::*;
#(
  parameter int unsigned NCH = NUM_CH
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   freeze,
  input  logic                   cap_valid,
  input  logic [ADDR_W-1:0]      cap_sel,
  input  res_t                   cap_data,
  output logic [NCH-1:0][RES_W-1:0] stage_q
);
  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic en;
    res_t d;
    always_comb begin
      en = cap_valid && !freeze && (cap_sel == ADDR_W'(g));
      d  = en ? cap_data : stage_q[g];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[g] <= '0;
      else        stage_q[g] <= d;
    end
  end
endmodule

// File: rtl/mon_publish.sv
module mon_publish
  import mon_pkg::*;
#(
  parameter int unsigned NCH = NUM_CH
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      tick,
  input  logic                      freeze,
  input  logic [NCH-1:0][RES_W-1:0] stage_q,
  input  logic [NCH-1:0]            host_we,
  input  res_t                      host_wdata,
  output logic [NCH-1:0][RES_W-1:0] res_q,
  output logic [NCH-1:0]            pub_we
);
  localparam int unsigned IDX_W = (NCH > 1) ? $clog2(NCH) : 1;
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(NCH - 1);

  logic             active_q, active_d;
  logic [IDX_W-1:0] idx_q, idx_d;

  always_comb begin
    active_d = active_q;
    idx_d    = idx_q;
    if (freeze) begin
      active_d = 1'b0;
      idx_d    = '0;
    end else if (tick) begin
      active_d = 1'b1;
      idx_d    = '0;
    end else if (active_q) begin
      if (idx_q == IDX_LAST) begin
        active_d = 1'b0;
        idx_d    = '0;
      end else begin
        idx_d = idx_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      idx_q    <= '0;
    end else begin
      active_q <= active_d;
      idx_q    <= idx_d;
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_res
    res_t d;
    always_comb begin
      pub_we[g] = active_q && !freeze && (idx_q == IDX_W'(g));
      if (pub_we[g])       d = stage_q[g];
      else if (host_we[g]) d = host_wdata;
      else                 d = res_q[g];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) res_q[g] <= '0;
      else        res_q[g] <= d;
    end
  end
endmodule

// File: rtl/mon_result_bank.sv
module mon_result_bank
  import mon_pkg::*;
#(
  parameter int unsigned CLK_HZ    = 200_000_000,
  parameter int unsigned UPDATE_HZ = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cap_valid,
  input  logic [1:0] cap_sel,
  input  logic [7:0] cap_data,
  input  logic       host_wr,
  input  logic [1:0] host_addr,
  input  logic [7:0] host_wdata,
  output logic [7:0] host_rdata
);
  localparam int unsigned DIV = CLK_HZ / UPDATE_HZ;

  logic [1:0] rst_sync_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  logic test_q, test_d;
  always_comb begin
    test_d = test_q;
    if (host_wr && (host_addr == ADR_CTRL)) test_d = host_wdata[CTRL_TEST_BIT];
  end
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) test_q <= 1'b0;
    else             test_q <= test_d;
  end

  logic [NUM_CH-1:0] host_we;
  for (genvar g = 0; g < NUM_CH; g++) begin : g_we
    assign host_we[g] = test_q && host_wr && (host_addr == ADDR_W'(g));
  end

  logic                         tick;
  logic [NUM_CH-1:0][RES_W-1:0] stage_q;
  logic [NUM_CH-1:0][RES_W-1:0] res_q;
  logic [NUM_CH-1:0]            pub_we;

  mon_rate_div #(.DIV(DIV)) div_i (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .tick  (tick)
  );

  mon_stage #(.NCH(NUM_CH)) stage_i (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .freeze    (test_q),
    .cap_valid (cap_valid),
    .cap_sel   (cap_sel),
    .cap_data  (cap_data),
    .stage_q   (stage_q)
  );

  mon_publish #(.NCH(NUM_CH)) pub_i (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .tick       (tick),
    .freeze     (test_q),
    .stage_q    (stage_q),
    .host_we    (host_we),
    .host_wdata (host_wdata),
    .res_q      (res_q),
    .pub_we     (pub_we)
  );

  always_comb begin
    case (host_addr)
      ADR_SENSE:  host_rdata = res_q[0];
      ADR_SOURCE: host_rdata = res_q[1];
      ADR_AUX:    host_rdata = res_q[2];
      default:    host_rdata = {{(RES_W-1){1'b0}}, test_q};
    endcase
  end
endmodule

// File: rtl/mon_result_bank_chk.sv
module mon_result_bank_chk (
  input logic            clk,
  input logic            rst_n,
  input logic            test_q,
  input logic            host_wr,
  input logic [1:0]      host_addr,
  input logic [7:0]      host_wdata,
  input logic [2:0]      pub_we,
  input logic [2:0][7:0] res_q
);
  a_r4_one_slot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pub_we));

  a_r4_source_after_sense: assert property (@(posedge clk) disable iff (!rst_n)
    pub_we[1] |-> $past(pub_we[0]));

  a_r4_aux_after_source: assert property (@(posedge clk) disable iff (!rst_n)
    pub_we[2] |-> $past(pub_we[1]));

  a_r6_sense_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (test_q && !(host_wr && host_addr == 2'd0)) |=> $stable(res_q[0]));

  a_r7_test_write: assert property (@(posedge clk) disable iff (!rst_n)
    (test_q && host_wr && host_addr == 2'd1) |=> (res_q[1] == $past(host_wdata)));

  a_r8_normal_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!test_q && !pub_we[2]) |=> $stable(res_q[2]));

  a_r5_mode_by_write: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_wr && host_addr == 2'd3) |=> $stable(test_q));
endmodule

bind mon_result_bank mon_result_bank_chk chk_i (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .test_q     (test_q),
  .host_wr    (host_wr),
  .host_addr  (host_addr),
  .host_wdata (host_wdata),
  .pub_we     (pub_we),
  .res_q      (res_q)
);

// File: tb/mon_result_bank_tb_top.sv
module mon_result_bank_tb_top;
  localparam int unsigned CLK_HZ    = 2000;
  localparam int unsigned UPDATE_HZ = 20;
  localparam int unsigned DIV       = CLK_HZ / UPDATE_HZ;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cap_valid = 1'b0;
  logic [1:0] cap_sel = '0;
  logic [7:0] cap_data = '0;
  logic       host_wr = 1'b0;
  logic [1:0] host_addr = '0;
  logic [7:0] host_wdata = '0;
  logic [7:0] host_rdata;

  always #2.5 clk = ~clk;

  mon_result_bank #(.CLK_HZ(CLK_HZ), .UPDATE_HZ(UPDATE_HZ)) dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cap_valid  (cap_valid),
    .cap_sel    (cap_sel),
    .cap_data   (cap_data),
    .host_wr    (host_wr),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .host_rdata (host_rdata)
  );

  typedef struct {
    string      tag;
    logic [7:0] exp;
  } exp_item_t;

  exp_item_t exp_q[$];
  logic      rd_req = 1'b0;
  int        checks = 0;
  int        errors = 0;
  longint    cyc = 0;
  bit        done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: pops expected items as reads are served
  always @(negedge clk) begin
    if (rd_req && exp_q.size() > 0) begin
      exp_item_t it;
      it = exp_q.pop_front();
      check8(it.tag, host_rdata, it.exp);
    end
  end

  task automatic expect_rd(input string tag, input logic [1:0] a, input logic [7:0] e);
    exp_item_t it;
    @(posedge clk); #1;
    host_addr = a;
    it.tag = tag;
    it.exp = e;
    exp_q.push_back(it);
    rd_req = 1'b1;
    @(negedge clk); #1;
    rd_req = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(posedge clk); #1;
    host_wr = 1'b0;
  endtask

  task automatic cap(input logic [1:0] s, input logic [7:0] d);
    @(posedge clk); #1;
    cap_valid = 1'b1; cap_sel = s; cap_data = d;
    @(posedge clk); #1;
    cap_valid = 1'b0;
  endtask

  task automatic poll(input string tag, input logic [1:0] a, input logic [7:0] want,
                      output longint at);
    bit found = 1'b0;
    at = 0;
    for (int i = 0; i < 3 * DIV; i++) begin
      @(posedge clk); #1;
      host_addr = a;
      @(negedge clk);
      if (host_rdata == want) begin
        found = 1'b1;
        at = cyc;
        break;
      end
    end
    checks++;
    if (!found) begin
      errors++;
      $display("FAIL %s actual %h expected %h (no publication seen)", tag, host_rdata, want);
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    longint c1, c2, tmp;
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    expect_rd("R1 sense", 2'd0, 8'h00);
    expect_rd("R1 source", 2'd1, 8'h00);
    expect_rd("R1 aux", 2'd2, 8'h00);
    expect_rd("R1 ctrl", 2'd3, 8'h00);

    // R2 staging, select 3 ignored, not visible yet
    cap(2'd0, 8'h11);
    cap(2'd1, 8'h22);
    cap(2'd2, 8'h33);
    cap(2'd3, 8'h44);
    expect_rd("R2 sense not yet visible", 2'd0, 8'h00);
    expect_rd("R10 source not yet visible", 2'd1, 8'h00);

    // R4 order: aux lands two cycles after sense
    poll("R2 sense published", 2'd0, 8'h11, c1);
    expect_rd("R4 aux still old one cycle after sense", 2'd2, 8'h00);
    expect_rd("R4 aux new two cycles after sense", 2'd2, 8'h33);
    expect_rd("R2 source published", 2'd1, 8'h22);
    expect_rd("R2 sel3 ignored sense", 2'd0, 8'h11);

    // R3 period
    cap(2'd0, 8'h5A);
    cap(2'd1, 8'hA5);
    cap(2'd2, 8'h3C);
    poll("R3 second publication", 2'd0, 8'h5A, c2);
    checks++;
    if (c2 - c1 != longint'(DIV)) begin
      errors++;
      $display("FAIL R3 period actual %0d expected %0d", c2 - c1, DIV);
    end
    expect_rd("R2 source second", 2'd1, 8'hA5);
    expect_rd("R2 aux second", 2'd2, 8'h3C);

    // R8 normal mode writes ignored
    wr(2'd0, 8'hFF);
    wr(2'd1, 8'hFF);
    wr(2'd2, 8'hFF);
    expect_rd("R8 sense unchanged", 2'd0, 8'h5A);
    expect_rd("R8 source unchanged", 2'd1, 8'hA5);
    expect_rd("R8 aux unchanged", 2'd2, 8'h3C);

    // R5 control readback
    wr(2'd3, 8'hFF);
    expect_rd("R5 ctrl only bit0", 2'd3, 8'h01);

    // R7 test-mode writes
    wr(2'd0, 8'h81);
    wr(2'd1, 8'h42);
    wr(2'd2, 8'h24);
    expect_rd("R7 sense written", 2'd0, 8'h81);
    expect_rd("R7 source written", 2'd1, 8'h42);
    expect_rd("R7 aux written", 2'd2, 8'h24);

    // R6 converter frozen
    cap(2'd0, 8'h99);
    cap(2'd1, 8'h99);
    cap(2'd2, 8'h99);
    repeat (2 * DIV) @(posedge clk);
    expect_rd("R6 sense frozen", 2'd0, 8'h81);
    expect_rd("R6 source frozen", 2'd1, 8'h42);
    expect_rd("R6 aux frozen", 2'd2, 8'h24);

    // R9 leave test mode
    wr(2'd3, 8'h00);
    expect_rd("R5 ctrl cleared", 2'd3, 8'h00);
    expect_rd("R9 sense held after exit", 2'd0, 8'h81);
    poll("R9 pre-test staged sense published", 2'd0, 8'h5A, tmp);
    expect_rd("R9 source from pre-test stage", 2'd1, 8'hA5);
    expect_rd("R9 aux from pre-test stage", 2'd2, 8'h3C);

    // R2 staging resumes
    cap(2'd2, 8'h07);
    poll("R2 aux after resume", 2'd2, 8'h07, tmp);
    expect_rd("R2 sense untouched by aux capture", 2'd0, 8'h5A);

    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule